// File: doc/BRIEF.md
# Card clock divider programmer

This block turns a request for a card clock rate into the settings a host controller's clock stage needs. The caller presents a base clock rate and a target card rate, both in Hz, and pulses a request. The block works out a 10-bit divider with a fixed rounding chain, packs it into a 16-bit clock-control word, and updates two automatic clock-gating enables and two delay-invert bits. When the rate moves above 52 MHz it raises a one-cycle request to enable the delay-locked loop. The divide is done by a radix-2 restoring divider that takes one cycle per quotient bit.

A finite state machine runs the request. The states are IDLE (waiting), CLKOFF (card clock held off after a rate change), START (choose the bypass path or launch the divider), DIVIDE (wait for the quotient) and APPLY (commit all results). The transitions are: IDLE to CLKOFF when a request brings a new rate; IDLE to START when the request repeats the current rate; CLKOFF to START always; START to APPLY when no division is needed; START to DIVIDE otherwise; DIVIDE to APPLY when the divider finishes; APPLY to IDLE always. The block remembers the last applied rate so that it can tell a new rate from a repeat.

Top module: `card_clk_div_prog`

## Requirements
- R1: After reset the clock-control word, both gating enables, both invert bits, the loop-enable request and busy are all 0, and the remembered rate is 0.
- R2: When the target is nonzero and the base rate is at most twice the target, the divider is 0.
- R3: Otherwise an intermediate value d is the base divided by twice the target, truncated, plus one when the base divided by d is still above twice the target.
- R4: The divider is d halved with rounding up ((d+1)/2 when d is odd, d/2 when even), then limited to at most 1023.
- R5: For a nonzero target the word holds divider bits 7:0 in word bits 15:8, divider bits 9:8 in word bits 7:6, internal clock enable in bit 0 and card clock enable in bit 2; all other bits are 0.
- R6: A target of 0 makes the whole word 0 and leaves the gating enables and invert bits as they were, with no loop-enable request.
- R7: After a nonzero target is applied, both gating enables are 1 when the target exceeds 400000 and both are 0 otherwise, whether or not the rate changed.
- R8: When a request brings a new rate, in the first busy cycle the card clock enable (bit 2) is 0 while the divider fields (bits 15:6) still hold the old divider.
- R9: On a change to a nonzero rate the command and read delay invert bits are both set to 1 when the target is at most 400000 and both cleared otherwise; a repeat of the current rate leaves them unchanged.
- R10: The loop-enable request is a one-cycle pulse in the first cycle that busy is low after a change to a rate above 52000000; a repeat of the current rate gives no pulse.
- R11: Busy is high from the cycle after an accepted request until the results appear; the word's divider fields, gating enables and invert bits do not move while busy and all change in the cycle busy falls; a request seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken when not busy |
| base_rate | input | 32 | Base clock rate in Hz |
| target_rate | input | 32 | Requested card clock rate in Hz |
| busy | output | 1 | High while a request is being processed |
| clk_ctrl | output | 16 | Packed clock-control word |
| gate_outer | output | 1 | Outer automatic clock-gating enable |
| gate_inner | output | 1 | Inner automatic clock-gating enable |
| cmd_dly_inv | output | 1 | Command delay invert |
| rd_dly_inv | output | 1 | Positive-edge read delay invert |
| dll_en_req | output | 1 | One-cycle request to enable the delay-locked loop |

## Verification
The two functions that can meet in one cycle are the commit of a finished request and the arrival of the next request. The bench holds the strobe high, with a different target, through the whole busy window, so that it is still high on the very edge at which APPLY commits. It judges the outcome by requiring that the committed results match the first target, and by then repeating that first target and seeing no card clock gap, no invert change and no loop-enable pulse, which shows the second target never reached the remembered rate.

// File: rtl/ccdp_pkg.sv
package ccdp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLKOFF,
        ST_START,
        ST_DIVIDE,
        ST_APPLY
    } ccdp_state_e;

    localparam int WORD_W      = 16;
    localparam int DIV_W       = 10;
    localparam int INT_EN_BIT  = 0;
    localparam int CARD_EN_BIT = 2;

endpackage

// File: rtl/ccdp_iter_div.sv
module ccdp_iter_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W:0]   divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W:0]   rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0] dvd_q;
    logic [W-1:0] dvd_cap;
    logic [W:0]   dsr_q;
    logic [CW-1:0] cnt_q;
    logic          active_q;
    logic [W+1:0]  trial;
    logic [W+1:0]  diff;
    logic          fits;

    always_comb begin
        trial = {rem, dvd_q[W-1]};
        fits  = (trial >= {1'b0, dsr_q});
        diff  = trial - {1'b0, dsr_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q    <= '0;
            dvd_cap  <= '0;
            dsr_q    <= '0;
            rem      <= '0;
            quot     <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            done     <= 1'b0;
        end else if (start) begin
            dvd_q    <= dividend;
            dvd_cap  <= dividend;
            dsr_q    <= divisor;
            rem      <= '0;
            quot     <= '0;
            cnt_q    <= CW'(W);
            active_q <= 1'b1;
            done     <= 1'b0;
        end else if (active_q) begin
            rem   <= fits ? diff[W:0] : trial[W:0];
            quot  <= {quot[W-2:0], fits};
            dvd_q <= dvd_q << 1;
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                active_q <= 1'b0;
                done     <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    // R3
    div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((2*W+2)'(quot) * (2*W+2)'(dsr_q) + (2*W+2)'(rem)) == (2*W+2)'(dvd_cap)
                  && rem < dsr_q));

endmodule

// File: rtl/ccdp_round.sv
module ccdp_round #(
    parameter int W       = 32,
    parameter int DIV_W   = 10,
    parameter int DIV_MAX = 1023
) (
    input  logic [W-1:0]     quot,
    input  logic [W:0]       rem,
    output logic [DIV_W-1:0] div
);
    logic [W+1:0] d_adj;
    logic [W+1:0] half;

    always_comb begin
        // truncated quotient, bumped when base / d still exceeds twice the target
        d_adj = {2'b00, quot} + ((rem >= {1'b0, quot}) ? (W+2)'(1) : (W+2)'(0));
        half  = (d_adj + (W+2)'(1)) >> 1;
        div   = (half > (W+2)'(DIV_MAX)) ? DIV_W'(DIV_MAX) : half[DIV_W-1:0];
    end

endmodule

// File: rtl/card_clk_div_prog.sv
module card_clk_div_prog #(
    parameter int RATE_W  = 32,
    parameter int DIV_MAX = 1023,
    parameter int SLOW_HZ = 400000,
    parameter int DLL_HZ  = 52000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [RATE_W-1:0] base_rate,
    input  logic [RATE_W-1:0] target_rate,
    output logic              busy,
    output logic [15:0]       clk_ctrl,
    output logic              gate_outer,
    output logic              gate_inner,
    output logic              cmd_dly_inv,
    output logic              rd_dly_inv,
    output logic              dll_en_req
);
    import ccdp_pkg::*;

    localparam logic [RATE_W-1:0] SLOW_LIM = RATE_W'(SLOW_HZ);
    localparam logic [RATE_W-1:0] DLL_LIM  = RATE_W'(DLL_HZ);

    ccdp_state_e state_q, state_d;

    logic [RATE_W-1:0] base_q, tgt_q, cur_q;
    logic              chg_q, quick_q;
    logic [RATE_W:0]   twice_tgt;
    logic              quick_now;
    logic              div_start, div_done;
    logic [RATE_W-1:0] quot;
    logic [RATE_W:0]   rem;
    logic [DIV_W-1:0]  div_round, div_val;
    logic [WORD_W-1:0] word_new;

    assign twice_tgt = {tgt_q, 1'b0};
    assign quick_now = (tgt_q == '0) || ({1'b0, base_q} <= twice_tgt);
    assign div_start = (state_q == ST_START) && !quick_now;
    assign busy      = (state_q != ST_IDLE);

    ccdp_iter_div #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (base_q),
        .divisor  (twice_tgt),
        .done     (div_done),
        .quot     (quot),
        .rem      (rem)
    );

    ccdp_round #(.W(RATE_W), .DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_round (
        .quot (quot),
        .rem  (rem),
        .div  (div_round)
    );

    always_comb begin
        div_val  = quick_q ? '0 : div_round;
        word_new = '0;
        word_new[15:8]        = div_val[7:0];
        word_new[7:6]         = div_val[9:8];
        word_new[INT_EN_BIT]  = 1'b1;
        word_new[CARD_EN_BIT] = 1'b1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = (target_rate != cur_q) ? ST_CLKOFF : ST_START;
            ST_CLKOFF: state_d = ST_START;
            ST_START:  state_d = quick_now ? ST_APPLY : ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_APPLY;
            ST_APPLY:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            tgt_q       <= '0;
            cur_q       <= '0;
            chg_q       <= 1'b0;
            quick_q     <= 1'b0;
            clk_ctrl    <= '0;
            gate_outer  <= 1'b0;
            gate_inner  <= 1'b0;
            cmd_dly_inv <= 1'b0;
            rd_dly_inv  <= 1'b0;
            dll_en_req  <= 1'b0;
        end else begin
            dll_en_req <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req) begin
                    base_q <= base_rate;
                    tgt_q  <= target_rate;
                    chg_q  <= (target_rate != cur_q);
                    if (target_rate != cur_q) clk_ctrl[CARD_EN_BIT] <= 1'b0;
                end
                ST_START: quick_q <= quick_now;
                ST_APPLY: begin
                    cur_q <= tgt_q;
                    if (tgt_q == '0) begin
                        clk_ctrl <= '0;
                    end else begin
                        clk_ctrl   <= word_new;
                        gate_outer <= (tgt_q > SLOW_LIM);
                        gate_inner <= (tgt_q > SLOW_LIM);
                        if (chg_q) begin
                            cmd_dly_inv <= (tgt_q <= SLOW_LIM);
                            rd_dly_inv  <= (tgt_q <= SLOW_LIM);
                        end
                        dll_en_req <= chg_q && (tgt_q > DLL_LIM);
                    end
                end
                default: ;
            endcase
        end
    end

    // R6
    zero_rate_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cur_q == '0) |-> (clk_ctrl == '0));

    // R7
    gating_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cur_q != '0) |-> (gate_outer == (cur_q > SLOW_LIM) && gate_inner == gate_outer));

    // R8
    card_off_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && chg_q) |-> !clk_ctrl[CARD_EN_BIT]);

    // R10
    dll_when_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en_req |-> (!busy && cur_q > DLL_LIM));

    // R10
    dll_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en_req |=> !dll_en_req);

    // R11
    req_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_APPLY) |=> $stable(cur_q));

endmodule

// File: tb/card_clk_div_prog_tb.sv
`timescale 1ns/1ps
module card_clk_div_prog_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] base_rate = '0;
    logic [31:0] target_rate = '0;
    logic        busy;
    logic [15:0] clk_ctrl;
    logic        gate_outer, gate_inner, cmd_dly_inv, rd_dly_inv, dll_en_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    longint m_cur  = 0;
    longint m_word = 0;
    int     m_gate = 0;
    int     m_inv  = 0;

    always #2 clk = ~clk;

    card_clk_div_prog dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .base_rate   (base_rate),
        .target_rate (target_rate),
        .busy        (busy),
        .clk_ctrl    (clk_ctrl),
        .gate_outer  (gate_outer),
        .gate_inner  (gate_inner),
        .cmd_dly_inv (cmd_dly_inv),
        .rd_dly_inv  (rd_dly_inv),
        .dll_en_req  (dll_en_req)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint exp_word(longint b, longint t);
        longint d, dv;
        if (t == 0) return 0;
        if (b <= 2 * t) dv = 0;
        else begin
            d = b / (2 * t);
            if (b / d > 2 * t) d++;
            dv = (d % 2 != 0) ? (d + 1) / 2 : d / 2;
            if (dv > 1023) dv = 1023;
        end
        return ((dv & 255) << 8) | (((dv >> 8) & 3) << 6) | 5;
    endfunction

    task automatic run_req(string tag, longint b, longint t, bit hold, longint t_alt);
        longint ew;
        bit     chg;
        int     eg, ei, ed, n;
        @(negedge clk);
        base_rate = 32'(b); target_rate = 32'(t); req = 1'b1;
        chg = (t != m_cur);
        ew  = exp_word(b, t);
        eg  = (t == 0) ? m_gate : ((t > 400000) ? 1 : 0);
        ei  = (chg && t != 0) ? ((t <= 400000) ? 1 : 0) : m_inv;
        ed  = (chg && t > 52000000) ? 1 : 0;
        @(negedge clk);
        if (hold) target_rate = 32'(t_alt);
        else      req = 1'b0;
        chk({"R11 busy after accept ", tag}, busy, 1);
        if (chg) begin
            chk({"R8 card clock off ", tag}, clk_ctrl[2], 0);
            chk({"R8 old divider kept ", tag}, clk_ctrl[15:6], m_word[15:6]);
        end
        n = 0;
        while (busy && n < 200) begin
            chk({"R11 divider stable while busy ", tag}, clk_ctrl[15:6], m_word[15:6]);
            chk({"R11 gating stable while busy ", tag}, gate_outer, m_gate);
            chk({"R11 invert stable while busy ", tag}, cmd_dly_inv, m_inv);
            chk({"R11 no loop request while busy ", tag}, dll_en_req, 0);
            @(negedge clk);
            n++;
        end
        req = 1'b0;
        chk({"R11 finished ", tag}, busy, 0);
        chk({"R2 R3 R4 R5 R6 word ", tag}, clk_ctrl, ew);
        chk({"R7 outer gate ", tag}, gate_outer, eg);
        chk({"R7 inner gate ", tag}, gate_inner, eg);
        chk({"R9 command invert ", tag}, cmd_dly_inv, ei);
        chk({"R9 read invert ", tag}, rd_dly_inv, ei);
        chk({"R10 loop request ", tag}, dll_en_req, ed);
        @(negedge clk);
        chk({"R10 loop request one cycle ", tag}, dll_en_req, 0);
        m_cur = t; m_word = ew; m_gate = eg; m_inv = ei;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R11 watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 word", clk_ctrl, 0);
        chk("R1 gates", {gate_outer, gate_inner}, 0);
        chk("R1 inverts", {cmd_dly_inv, rd_dly_inv}, 0);
        chk("R1 loop request", dll_en_req, 0);
        chk("R1 busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_req("slow rate with increment", 26000000, 400000, 0, 0);        // R3 d=33, div 17
        run_req("even quotient no increment", 384000000, 100000, 0, 0);     // R4 div 960
        run_req("divider 1000", 400000000, 100000, 0, 0);                   // R4
        run_req("clamp to 1023", 1000000000, 100000, 0, 0);                 // R4
        run_req("odd quotient", 100000000, 3000000, 0, 0);                  // R4 div 9
        run_req("fast increment to 2", 400000000, 150000000, 0, 0);         // R3 R10
        run_req("bypass fast", 200000000, 200000000, 0, 0);                 // R2 R10
        run_req("repeat fast", 200000000, 200000000, 0, 0);                 // R9 R10 repeat
        run_req("request held while busy", 100000000, 3000000, 1, 1000000); // R11
        run_req("repeat after held request", 100000000, 3000000, 0, 0);     // R11
        run_req("zero target", 100000000, 0, 0, 0);                         // R6
        run_req("bypass from zero", 26000000, 25000000, 0, 0);              // R2
        run_req("back to slow", 26000000, 400000, 0, 0);                    // R9

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule